// File: doc/BRIEF.md
# Event Source Gate Array

This block keeps a two-bit state machine for every interrupt event source and decides whether each incoming trigger is passed on to routing. One bit records that an event has been sent and still awaits its end-of-interrupt (EOI). The other bit records that another event arrived while the first was outstanding, or, when it is set alone, that the source is switched off. Triggers arrive as single-cycle pulses tagged with a source index. A second port carries accesses that read a source, load its state directly, change its configuration, or signal EOI.

The block has two forward lanes. A trigger that is let through leaves on the trigger lane. An event that an EOI re-fires from a queued state leaves on the EOI lane. Each lane raises a one-cycle request, registered one clock after the input, and carries the source index. Every source also holds a mask bit and a type bit, which marks a source as message-signalled or level-signalled. A masked source still steps its state machine, but it emits no forward request.

State encoding throughout is {P,Q}: bit 1 is P and bit 0 is Q. 00 means ready, 10 means sent with EOI pending, 11 means sent plus one queued, and 01 means off.

Top module: `evsrc_gate`

## Requirements
- R1: After reset every source reads back state 01 (off), mask 1 and type 0, and neither forward lane is active.
- R2: A trigger to an unmasked source in state 00 moves it to 10 and raises trig_fwd_vld one cycle later with trig_fwd_src equal to the source index.
- R3: A trigger to a source in state 10 or 11 leaves it in 11 and raises no forward request.
- R4: A trigger to a source in state 01 is ignored: the state stays 01 and no forward request is raised.
- R5: An EOI access (op code 1) moves 10 to 00 without a forward request. It moves 11 to 10 and raises eoi_fwd_vld one cycle later with eoi_fwd_src equal to the source. It leaves 00 and 01 unchanged.
- R6: When a source's mask is 1 at the start of the cycle, neither lane forwards for that source, but its state still changes exactly as in R2, R3 and R5.
- R7: Every access raises rd_vld one cycle later. rd_data carries the values held before the access: bit 3 is type, bit 2 is mask, and bits 1:0 are {P,Q}. Op 0 reads only. Op 2 loads acc_wdata[1:0] as the new state. Op 3 loads mask from acc_wdata[2] and type from acc_wdata[3].
- R8: When a trigger and an access hit the same source in the same cycle, the access is applied first and the trigger acts on the resulting state. A trigger and an EOI to different sources can both forward in the same cycle, one on each lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_vld | input | 1 | Trigger pulse |
| trig_src | input | IW | Source index of the trigger |
| acc_vld | input | 1 | Access strobe |
| acc_op | input | 2 | 0 read, 1 EOI, 2 load state, 3 load config |
| acc_src | input | IW | Source index of the access |
| acc_wdata | input | 4 | Write data: [1:0] state, [2] mask, [3] type |
| rd_vld | output | 1 | Readback valid, one cycle after the access |
| rd_data | output | 4 | Readback of the values held before the access |
| trig_fwd_vld | output | 1 | Forward request from the trigger lane |
| trig_fwd_src | output | IW | Source index on the trigger lane |
| eoi_fwd_vld | output | 1 | Forward request from an EOI re-fire |
| eoi_fwd_src | output | IW | Source index on the EOI lane |

## Verification
A trigger and an access can land in the same cycle. When both target one source, the access result feeds the trigger step. The bench provokes this for every source, in all four states and with both mask values, by driving a trigger and an EOI to that source together. It then judges the forward lanes and a follow-up read against a model that applies the EOI step before the trigger step. The case where both lanes fire at once is provoked by triggering one source in state 00 while sending an EOI to a different source in state 11, and both lanes are expected in the same cycle.

// File: rtl/evsrc_pkg.sv
package evsrc_pkg;

  localparam logic [1:0] OP_READ = 2'd0;
  localparam logic [1:0] OP_EOI  = 2'd1;
  localparam logic [1:0] OP_SET  = 2'd2;
  localparam logic [1:0] OP_CFG  = 2'd3;

  localparam logic [1:0] PQ_READY  = 2'b00;
  localparam logic [1:0] PQ_OFF    = 2'b01;
  localparam logic [1:0] PQ_PEND   = 2'b10;
  localparam logic [1:0] PQ_QUEUED = 2'b11;

  typedef struct packed {
    logic [1:0] pq;
    logic       fire;
  } step_t;

  // Effect of a trigger on one source state
  function automatic step_t trig_step(input logic [1:0] pq);
    step_t r;
    r.fire = 1'b0;
    r.pq   = pq;
    unique case (pq)
      PQ_READY:  begin r.pq = PQ_PEND; r.fire = 1'b1; end
      PQ_PEND,
      PQ_QUEUED: r.pq = PQ_QUEUED;
      default:   r.pq = PQ_OFF;
    endcase
    return r;
  endfunction

  // Effect of a register access on one source state
  function automatic step_t acc_step(input logic [1:0] pq, input logic [1:0] op,
                                     input logic [1:0] wpq);
    step_t r;
    r.fire = 1'b0;
    r.pq   = pq;
    unique case (op)
      OP_EOI: begin
        if (pq == PQ_QUEUED) begin
          r.pq   = PQ_PEND;
          r.fire = 1'b1;
        end else if (pq == PQ_PEND) begin
          r.pq = PQ_READY;
        end
      end
      OP_SET:  r.pq = wpq;
      default: r.pq = pq;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/evsrc_cell.sv
module evsrc_cell
  import evsrc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_hit,
  input  logic [1:0] acc_op,
  input  logic [3:0] acc_wdata,
  input  logic       trig_hit,
  output logic [1:0] pq_o,
  output logic       mask_o,
  output logic       type_o,
  output logic       trig_fire_o,
  output logic       eoi_fire_o
);

  logic [1:0] pq_q;
  logic       mask_q;
  logic       type_q;
  step_t      acc_r;
  step_t      trig_r;
  logic       cfg_wr;

  always_comb begin
    acc_r.pq   = pq_q;
    acc_r.fire = 1'b0;
    if (acc_hit) acc_r = acc_step(pq_q, acc_op, acc_wdata[1:0]);
    trig_r.pq   = acc_r.pq;
    trig_r.fire = 1'b0;
    if (trig_hit) trig_r = trig_step(acc_r.pq);
  end

  assign cfg_wr      = acc_hit && (acc_op == OP_CFG);
  assign trig_fire_o = trig_r.fire & ~mask_q;
  assign eoi_fire_o  = acc_r.fire & ~mask_q;
  assign pq_o        = pq_q;
  assign mask_o      = mask_q;
  assign type_o      = type_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pq_q   <= PQ_OFF;
      mask_q <= 1'b1;
      type_q <= 1'b0;
    end else begin
      pq_q <= trig_r.pq;
      if (cfg_wr) begin
        mask_q <= acc_wdata[2];
        type_q <= acc_wdata[3];
      end
    end
  end

  // R2
  ready_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_hit && !acc_hit && pq_q == PQ_READY) |=> (pq_q == PQ_PEND));

  // R3
  coalesce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_hit && !acc_hit && pq_q[1]) |=> (pq_q == PQ_QUEUED));

  // R4
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_hit && !acc_hit && pq_q == PQ_OFF) |=> (pq_q == PQ_OFF));

  // R5
  eoi_requeue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_hit && acc_op == OP_EOI && !trig_hit && pq_q == PQ_QUEUED) |=> (pq_q == PQ_PEND));

  // R6
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |-> (!trig_fire_o && !eoi_fire_o));

endmodule

// File: rtl/evsrc_pipe.sv
module evsrc_pipe #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_i,
  input  logic [W-1:0] dat_i,
  output logic         vld_o,
  output logic [W-1:0] dat_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      dat_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) dat_o <= dat_i;
    end
  end

endmodule

// File: rtl/evsrc_gate.sv
module evsrc_gate
  import evsrc_pkg::*;
#(
  parameter int N_SRC = 64,
  localparam int IW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_vld,
  input  logic [IW-1:0] trig_src,
  input  logic          acc_vld,
  input  logic [1:0]    acc_op,
  input  logic [IW-1:0] acc_src,
  input  logic [3:0]    acc_wdata,
  output logic          rd_vld,
  output logic [3:0]    rd_data,
  output logic          trig_fwd_vld,
  output logic [IW-1:0] trig_fwd_src,
  output logic          eoi_fwd_vld,
  output logic [IW-1:0] eoi_fwd_src
);

  logic [N_SRC-1:0] trig_fire_vec;
  logic [N_SRC-1:0] eoi_fire_vec;
  logic [1:0]       pq_arr   [N_SRC];
  logic [N_SRC-1:0] mask_vec;
  logic [N_SRC-1:0] type_vec;
  logic [3:0]       rd_next;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    evsrc_cell u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_hit    (acc_vld && (acc_src == IW'(i))),
      .acc_op     (acc_op),
      .acc_wdata  (acc_wdata),
      .trig_hit   (trig_vld && (trig_src == IW'(i))),
      .pq_o       (pq_arr[i]),
      .mask_o     (mask_vec[i]),
      .type_o     (type_vec[i]),
      .trig_fire_o(trig_fire_vec[i]),
      .eoi_fire_o (eoi_fire_vec[i])
    );
  end

  assign rd_next = {type_vec[acc_src], mask_vec[acc_src], pq_arr[acc_src]};

  evsrc_pipe #(.W(4)) u_rd (
    .clk(clk), .rst_n(rst_n), .vld_i(acc_vld), .dat_i(rd_next),
    .vld_o(rd_vld), .dat_o(rd_data)
  );

  evsrc_pipe #(.W(IW)) u_trig_lane (
    .clk(clk), .rst_n(rst_n), .vld_i(|trig_fire_vec), .dat_i(trig_src),
    .vld_o(trig_fwd_vld), .dat_o(trig_fwd_src)
  );

  evsrc_pipe #(.W(IW)) u_eoi_lane (
    .clk(clk), .rst_n(rst_n), .vld_i(|eoi_fire_vec), .dat_i(acc_src),
    .vld_o(eoi_fwd_vld), .dat_o(eoi_fwd_src)
  );

  // R8
  one_fire_per_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($onehot0(trig_fire_vec) && $onehot0(eoi_fire_vec)));

  // R2
  trig_fwd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig_fire_vec) |=> (trig_fwd_vld && trig_fwd_src == $past(trig_src)));

  // R5
  eoi_fwd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|eoi_fire_vec) |=> (eoi_fwd_vld && eoi_fwd_src == $past(acc_src)));

  // R5
  eoi_only_on_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_op != OP_EOI || !acc_vld) |=> !eoi_fwd_vld);

  // R7
  rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld |=> rd_vld);

endmodule

// File: tb/evsrc_gate_tb.sv
`timescale 1ns/1ps
module evsrc_gate_tb;

  localparam int N  = 64;
  localparam int IW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trig_vld = 1'b0;
  logic [IW-1:0] trig_src = '0;
  logic          acc_vld = 1'b0;
  logic [1:0]    acc_op = '0;
  logic [IW-1:0] acc_src = '0;
  logic [3:0]    acc_wdata = '0;
  logic          rd_vld;
  logic [3:0]    rd_data;
  logic          trig_fwd_vld;
  logic [IW-1:0] trig_fwd_src;
  logic          eoi_fwd_vld;
  logic [IW-1:0] eoi_fwd_src;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [1:0] m_pq   [N];
  logic       m_mask [N];
  logic       m_type [N];

  always #2.5 clk = ~clk;

  evsrc_gate #(.N_SRC(N)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .trig_vld(trig_vld), .trig_src(trig_src),
    .acc_vld(acc_vld), .acc_op(acc_op), .acc_src(acc_src), .acc_wdata(acc_wdata),
    .rd_vld(rd_vld), .rd_data(rd_data),
    .trig_fwd_vld(trig_fwd_vld), .trig_fwd_src(trig_fwd_src),
    .eoi_fwd_vld(eoi_fwd_vld), .eoi_fwd_src(eoi_fwd_src)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one cycle of stimulus; model predicts outputs from the requirement text
  task automatic cyc(input bit tv, input int ts, input bit av, input int aop,
                     input int as, input int awd, input string req);
    int  exp_rd;
    bit  exp_tf, exp_ef;
    bit  mk_t, mk_a;
    logic [1:0] p;
    exp_rd = {m_type[as], m_mask[as], m_pq[as]};
    mk_t = m_mask[ts];
    mk_a = m_mask[as];
    exp_tf = 1'b0;
    exp_ef = 1'b0;
    if (av) begin
      p = m_pq[as];
      if (aop == 1) begin
        if (p == 2'b11) begin m_pq[as] = 2'b10; exp_ef = !mk_a; end
        else if (p == 2'b10) m_pq[as] = 2'b00;
      end else if (aop == 2) begin
        m_pq[as] = awd[1:0];
      end else if (aop == 3) begin
        m_mask[as] = awd[2];
        m_type[as] = awd[3];
      end
    end
    if (tv) begin
      p = m_pq[ts];
      if (p == 2'b00) begin m_pq[ts] = 2'b10; exp_tf = !mk_t; end
      else if (p[1]) m_pq[ts] = 2'b11;
    end
    trig_vld  = tv;
    trig_src  = IW'(ts);
    acc_vld   = av;
    acc_op    = 2'(aop);
    acc_src   = IW'(as);
    acc_wdata = 4'(awd);
    @(posedge clk);
    @(negedge clk);
    trig_vld = 1'b0;
    acc_vld  = 1'b0;
    chk(req, "trig_fwd_vld", trig_fwd_vld, exp_tf);
    if (exp_tf) chk(req, "trig_fwd_src", trig_fwd_src, ts);
    chk(req, "eoi_fwd_vld", eoi_fwd_vld, exp_ef);
    if (exp_ef) chk(req, "eoi_fwd_src", eoi_fwd_src, as);
    chk(req, "rd_vld", rd_vld, av);
    if (av) chk(req, "rd_data", rd_data, exp_rd);
  endtask

  function automatic string act_req(input int act, input int st, input int m);
    if (act == 2) return "R8";
    if (m != 0)   return "R6";
    if (act == 1) return "R5";
    if (st == 1)  return "R4";
    if (st == 0)  return "R2";
    return "R3";
  endfunction

  initial begin
    for (int i = 0; i < N; i++) begin
      m_pq[i] = 2'b01; m_mask[i] = 1'b1; m_type[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle lanes and reset contents of every source
    chk("R1", "trig_fwd_vld", trig_fwd_vld, 0);
    chk("R1", "eoi_fwd_vld", eoi_fwd_vld, 0);
    chk("R1", "rd_vld", rd_vld, 0);
    for (int s = 0; s < N; s++) cyc(1'b0, 0, 1'b1, 0, s, 0, "R1");
    // R1/R4: trigger while off right after reset
    cyc(1'b1, 5, 1'b0, 0, 0, 0, "R4");
    cyc(1'b0, 0, 1'b1, 0, 5, 0, "R4");

    // sweep every source, state, mask value and action
    for (int s = 0; s < N; s++) begin
      for (int st = 0; st < 4; st++) begin
        for (int m = 0; m < 2; m++) begin
          for (int act = 0; act < 3; act++) begin
            cyc(1'b0, 0, 1'b1, 3, s, (s % 2) * 8 + m * 4, "R7");
            cyc(1'b0, 0, 1'b1, 2, s, st, "R7");
            cyc(act != 1, s, act != 0, 1, s, 0, act_req(act, st, m));
            cyc(1'b0, 0, 1'b1, 0, s, 0, act_req(act, st, m));
          end
        end
      end
    end

    // R8: both lanes in one cycle on different sources
    for (int s = 0; s < N; s += 7) begin
      int o;
      o = (s + 1) % N;
      cyc(1'b0, 0, 1'b1, 3, s, 0, "R8");
      cyc(1'b0, 0, 1'b1, 3, o, 0, "R8");
      cyc(1'b0, 0, 1'b1, 2, s, 0, "R8");
      cyc(1'b0, 0, 1'b1, 2, o, 3, "R8");
      cyc(1'b1, s, 1'b1, 1, o, 0, "R8");
      cyc(1'b0, 0, 1'b1, 0, s, 0, "R8");
      cyc(1'b0, 0, 1'b1, 0, o, 0, "R8");
    end

    // R3 then R5: coalesce two triggers, drain with two EOIs
    cyc(1'b0, 0, 1'b1, 3, 9, 0, "R3");
    cyc(1'b0, 0, 1'b1, 2, 9, 0, "R3");
    cyc(1'b1, 9, 1'b0, 0, 0, 0, "R2");
    cyc(1'b1, 9, 1'b0, 0, 0, 0, "R3");
    cyc(1'b1, 9, 1'b0, 0, 0, 0, "R3");
    cyc(1'b0, 0, 1'b1, 1, 9, 0, "R5");
    cyc(1'b0, 0, 1'b1, 1, 9, 0, "R5");
    cyc(1'b0, 0, 1'b1, 0, 9, 0, "R5");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule